// File: doc/BRIEF.md
# FIFO Retransmit Read Controller

This block is the read side of a FIFO whose stored contents can be read again from the beginning. It keeps the read pointer and drives the address of a storage array whose read data returns in the same cycle. It loads the addressed word into an output register on each accepted read. The write side supplies only its write pointer, and the block derives from it the number of words still readable.

Pulling the active-low rewind input low on a clock edge moves the read pointer back to array location 0, so the stored sequence can be replayed as often as needed. Two timing modes exist, chosen by a select pin that is sampled while master reset is active.

- **Zero-latency mode:** the word at location 0 enters the output register on the same edge that samples the rewind.
- **Normal mode:** the edge that samples the rewind only moves the pointer, and word 0 appears on the next read.

Top module: `rtr_read_ctl`

## Requirements
- R1: While reset is active and after it is released, `dout_vld` is 0, `dout` is 0, the read pointer is at location 0, so `mem_raddr` is 0 and `avail_cnt` equals `wr_ptr`.
- R2: On an edge with `rd_en` high, `rewind_n` high and `avail_cnt` nonzero, the word at the read pointer is loaded into `dout`. `dout_vld` is 1 for the following cycle, the pointer advances by one and `avail_cnt` drops by one.
- R3: A read request when `avail_cnt` is 0 is ignored: `dout_vld` is 0 afterwards, `dout` keeps its value and `avail_cnt` stays 0.
- R4: `rt_normal_sel` is sampled only while reset is active (0 = zero latency, 1 = normal latency). Changing it after reset has no effect until the next reset.
- R5: A low `rewind_n` sampled on a rising edge resets the read pointer to location 0. While `rewind_n` is low, `mem_raddr` is 0.
- R6: In zero-latency mode, with `wr_ptr` nonzero, the rewind edge loads word 0 into `dout` with `dout_vld` 1. The pointer moves to 1 and `avail_cnt` becomes `wr_ptr`-1.
- R7: In normal mode the rewind edge loads nothing: `dout_vld` is 0, `dout` holds, and `avail_cnt` becomes `wr_ptr`. The next read returns word 0.
- R8: When `rd_en` and a low `rewind_n` share an edge, the rewind wins: the outcome equals that of a rewind alone.
- R9: A zero-latency rewind while `wr_ptr` is 0 loads nothing, and `dout_vld` is 0 afterwards.
- R10: After a rewind, the same stored words are read out again in the same order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Read clock |
| rst_n | input | 1 | Asynchronous active-low master reset, released synchronously |
| rt_normal_sel | input | 1 | Retransmit timing select, sampled during reset: 0 zero latency, 1 normal |
| rd_en | input | 1 | Read request |
| rewind_n | input | 1 | Active-low retransmit request |
| wr_ptr | input | AW+1 | Write pointer from the write side, including its wrap bit |
| mem_raddr | output | AW | Read address to the storage array |
| mem_rdata | input | W | Word read from the array at `mem_raddr` in the same cycle |
| dout | output | W | Output data register |
| dout_vld | output | 1 | High for one cycle after a word was loaded into `dout` |
| avail_cnt | output | AW+1 | Readable words: `wr_ptr` minus the read pointer |

## Verification
Every result belongs to the edge that samples the request.

- `dout`, `dout_vld` and `avail_cnt` change on that edge.
- `mem_raddr` follows `rewind_n` with no register in between.

The bench drives inputs 1 time unit after a rising edge and checks outputs 1 time unit after the next rising edge. It checks `mem_raddr` before that edge, while `rewind_n` is held low.

For each fill level from 1 to 16 words, and in both timing modes, the bench rewinds, reads the whole content, makes one read past the end, and then rewinds with a simultaneous read. Every expected word comes from the bench's own arithmetic model of the array contents.

// File: rtl/rtr_pkg.sv
package rtr_pkg;
  typedef enum logic {
    LAT_ZERO   = 1'b0,
    LAT_NORMAL = 1'b1
  } rt_lat_e;
endpackage

// File: rtl/rtr_rstmode.sv
module rtr_rstmode
  import rtr_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic mode_pin,
  output logic rst_sync_n,
  output logic zero_lat
);
  logic    sync1_q, sync2_q;
  rt_lat_e mode_q, mode_d;

  // async assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= 1'b0;
      sync2_q <= 1'b0;
    end else begin
      sync1_q <= 1'b1;
      sync2_q <= sync1_q;
    end
  end

  assign rst_sync_n = sync2_q;

  // mode captured only while internal reset is active
  always_comb begin
    mode_d = mode_q;
    if (!sync2_q) mode_d = rt_lat_e'(mode_pin);
  end

  always_ff @(posedge clk) begin
    mode_q <= mode_d;
  end

  assign zero_lat = (mode_q == LAT_ZERO);

  assert_mode_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (sync2_q && $past(sync2_q)) |-> $stable(mode_q))
    else $error("retransmit mode changed outside reset");
endmodule

// File: rtl/rtr_rdptr.sv
module rtr_rdptr #(
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rst_sync_n,
  input  logic          zero_lat,
  input  logic          rd_en,
  input  logic          rewind_n,
  input  logic [AW:0]   wr_ptr,
  output logic [AW-1:0] raddr,
  output logic          load,
  output logic [AW:0]   avail
);
  localparam int PW    = AW + 1;
  localparam int DEPTH = 1 << AW;

  logic [PW-1:0] rd_q, rd_d;
  logic          rewind;

  assign rewind = !rewind_n;
  assign avail  = wr_ptr - rd_q;

  always_comb begin
    rd_d  = rd_q;
    load  = 1'b0;
    raddr = rd_q[AW-1:0];
    if (rewind) begin
      raddr = '0;
      if (zero_lat && (wr_ptr != '0)) begin
        load = 1'b1;
        rd_d = PW'(1);
      end else begin
        rd_d = '0;
      end
    end else if (rd_en && (avail != '0)) begin
      load = 1'b1;
      rd_d = rd_q + PW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           rd_q <= '0;
    else if (!rst_sync_n) rd_q <= '0;
    else                  rd_q <= rd_d;
  end

  assert_ptr_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    avail <= PW'(DEPTH))
    else $error("read pointer passed write pointer");

  assert_rewind_normal_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_sync_n && rewind && !zero_lat) |=> (rd_q == '0))
    else $error("normal rewind did not reach location 0");

  assert_rewind_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_sync_n && rewind && zero_lat && (wr_ptr != '0)) |=> (rd_q == PW'(1)))
    else $error("zero-latency rewind did not step past location 0");
endmodule

// File: rtl/rtr_outreg.sv
module rtr_outreg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         rst_sync_n,
  input  logic         load,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout,
  output logic         vld
);
  logic [W-1:0] dat_q, dat_d;
  logic         vld_q, vld_d;

  always_comb begin
    dat_d = dat_q;
    vld_d = load;
    if (load) dat_d = din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dat_q <= '0;
      vld_q <= 1'b0;
    end else if (!rst_sync_n) begin
      dat_q <= '0;
      vld_q <= 1'b0;
    end else begin
      dat_q <= dat_d;
      vld_q <= vld_d;
    end
  end

  assign dout = dat_q;
  assign vld  = vld_q;

  assert_hold_when_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_sync_n && !load) |=> ($stable(dat_q) && !vld_q))
    else $error("output register moved without a load");
endmodule

// File: rtl/rtr_read_ctl.sv
module rtr_read_ctl #(
  parameter int W  = 8,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rt_normal_sel,
  input  logic          rd_en,
  input  logic          rewind_n,
  input  logic [AW:0]   wr_ptr,
  output logic [AW-1:0] mem_raddr,
  input  logic [W-1:0]  mem_rdata,
  output logic [W-1:0]  dout,
  output logic          dout_vld,
  output logic [AW:0]   avail_cnt
);
  logic rst_sync_n;
  logic zero_lat;
  logic load;

  rtr_rstmode u_rstmode (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_pin   (rt_normal_sel),
    .rst_sync_n (rst_sync_n),
    .zero_lat   (zero_lat)
  );

  rtr_rdptr #(.AW(AW)) u_rdptr (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n),
    .zero_lat   (zero_lat),
    .rd_en      (rd_en),
    .rewind_n   (rewind_n),
    .wr_ptr     (wr_ptr),
    .raddr      (mem_raddr),
    .load       (load),
    .avail      (avail_cnt)
  );

  rtr_outreg #(.W(W)) u_outreg (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n),
    .load       (load),
    .din        (mem_rdata),
    .dout       (dout),
    .vld        (dout_vld)
  );

  assert_vld_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
    dout_vld |-> $past(rd_en || !rewind_n))
    else $error("valid without a read or rewind request");

  assert_rewind_addr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !rewind_n |-> (mem_raddr == '0))
    else $error("rewind does not address location 0");

  assert_empty_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_sync_n && rd_en && rewind_n && (avail_cnt == '0)) |=> (!dout_vld && $stable(dout)))
    else $error("read accepted with nothing available");

  assert_rewind_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_sync_n && !rewind_n && rd_en && !zero_lat) |=> !dout_vld)
    else $error("read not overridden by normal rewind");
endmodule

// File: tb/tb_rtr_read_ctl.sv
module tb_rtr_read_ctl;
  localparam int CLK_PERIOD = 10;
  localparam int W  = 8;
  localparam int AW = 4;
  localparam int DEPTH = 1 << AW;

  logic          clk;
  logic          rst_n;
  logic          rt_normal_sel;
  logic          rd_en;
  logic          rewind_n;
  logic [AW:0]   wr_ptr;
  logic [AW-1:0] mem_raddr;
  logic [W-1:0]  mem_rdata;
  logic [W-1:0]  dout;
  logic          dout_vld;
  logic [AW:0]   avail_cnt;

  int checks   = 0;
  int failures = 0;

  rtr_read_ctl #(.W(W), .AW(AW)) dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .rt_normal_sel (rt_normal_sel),
    .rd_en         (rd_en),
    .rewind_n      (rewind_n),
    .wr_ptr        (wr_ptr),
    .mem_raddr     (mem_raddr),
    .mem_rdata     (mem_rdata),
    .dout          (dout),
    .dout_vld      (dout_vld),
    .avail_cnt     (avail_cnt)
  );

  function automatic logic [W-1:0] word_at(int i);
    return W'((i * 37 + 5) & 255);
  endfunction

  assign mem_rdata = word_at(int'(mem_raddr));

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset(logic sel);
    rst_n = 1'b0;
    rt_normal_sel = sel;
    rd_en = 1'b0;
    rewind_n = 1'b1;
    wr_ptr = '0;
    repeat (3) tick();
    rst_n = 1'b1;
    repeat (3) tick();
  endtask

  initial begin
    logic [W-1:0] last;
    rst_n = 1'b0; rt_normal_sel = 1'b0; rd_en = 1'b0; rewind_n = 1'b1; wr_ptr = '0;

    // ---------------- zero-latency mode ----------------
    do_reset(1'b0);
    check("R1 vld", dout_vld, 0);
    check("R1 dout", dout, 0);
    check("R1 avail", avail_cnt, 0);
    check("R1 raddr", mem_raddr, 0);
    rt_normal_sel = 1'b1; // R4: must not switch mode
    rd_en = 1'b1; tick(); rd_en = 1'b0;
    check("R3 empty vld", dout_vld, 0);
    check("R3 empty dout", dout, 0);
    check("R3 empty avail", avail_cnt, 0);
    rewind_n = 1'b0; tick(); rewind_n = 1'b1;
    check("R9 vld", dout_vld, 0);
    check("R9 avail", avail_cnt, 0);
    for (int n = 1; n <= DEPTH; n++) begin
      wr_ptr = (AW+1)'(n);
      rewind_n = 1'b0; #1;
      check("R5 raddr", mem_raddr, 0);
      tick(); rewind_n = 1'b1;
      check("R6 R4 dout", dout, word_at(0));
      check("R6 vld", dout_vld, 1);
      check("R6 avail", avail_cnt, n - 1);
      for (int k = 1; k < n; k++) begin
        rd_en = 1'b1; tick(); rd_en = 1'b0;
        check("R2 dout", dout, word_at(k));
        check("R2 vld", dout_vld, 1);
        check("R2 avail", avail_cnt, n - 1 - k);
      end
      rd_en = 1'b1; tick(); rd_en = 1'b0;
      check("R3 vld", dout_vld, 0);
      check("R3 dout", dout, word_at(n - 1));
      check("R3 avail", avail_cnt, 0);
      rewind_n = 1'b0; rd_en = 1'b1; tick(); rewind_n = 1'b1; rd_en = 1'b0;
      check("R8 dout", dout, word_at(0));
      check("R8 vld", dout_vld, 1);
      check("R8 avail", avail_cnt, n - 1);
      if (n > 1) begin
        rd_en = 1'b1; tick(); rd_en = 1'b0;
        check("R10 dout", dout, word_at(1));
        check("R10 avail", avail_cnt, n - 2);
      end
    end

    // ---------------- normal-latency mode ----------------
    do_reset(1'b1);
    check("R1 vld", dout_vld, 0);
    check("R1 dout", dout, 0);
    check("R1 avail", avail_cnt, 0);
    rt_normal_sel = 1'b0; // R4: must not switch mode
    rewind_n = 1'b0; tick(); rewind_n = 1'b1;
    check("R7 empty vld", dout_vld, 0);
    last = '0;
    for (int n = 1; n <= DEPTH; n++) begin
      wr_ptr = (AW+1)'(n);
      rewind_n = 1'b0; #1;
      check("R5 raddr", mem_raddr, 0);
      tick(); rewind_n = 1'b1;
      check("R7 R4 vld", dout_vld, 0);
      check("R7 dout held", dout, last);
      check("R7 avail", avail_cnt, n);
      for (int k = 0; k < n; k++) begin
        rd_en = 1'b1; tick(); rd_en = 1'b0;
        check("R10 R2 dout", dout, word_at(k));
        check("R2 vld", dout_vld, 1);
        check("R2 avail", avail_cnt, n - 1 - k);
      end
      last = word_at(n - 1);
      rd_en = 1'b1; tick(); rd_en = 1'b0;
      check("R3 vld", dout_vld, 0);
      check("R3 dout", dout, last);
      rewind_n = 1'b0; rd_en = 1'b1; tick(); rewind_n = 1'b1; rd_en = 1'b0;
      check("R8 vld", dout_vld, 0);
      check("R8 dout", dout, last);
      check("R8 avail", avail_cnt, n);
      rd_en = 1'b1; tick(); rd_en = 1'b0;
      check("R7 first word", dout, word_at(0));
      check("R7 avail", avail_cnt, n - 1);
      last = word_at(0);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule